// File: doc/BRIEF.md
# Paged I2C Register Target

This block is an I2C target that gives an I2C host byte-wide access to a bank of 8-bit registers split into pages of 128 entries. It handles SCL and SDA as open-drain lines: it samples both lines on the system clock and only ever pulls SDA low through an enable. Multi-byte writes and reads step a register pointer after each byte. The pointer never crosses into the next page. A side port lets neighbouring logic read any stored register without going through the bus.

A watchdog guards against noise that leaves a transfer stuck with the target holding SDA low. When that happens it drops SDA, returns the target to idle so that a fresh START is accepted, and records the event in a sticky flag. The flag and a disable bit sit in a control register on page 0. The watchdog is active after reset.

Top module: `i2cpg_target`

## Requirements
- R1: The target acknowledges (SDA low on the 9th clock) only an address byte whose upper 7 bits equal `DEV_ADDR`. Any other address gets no acknowledge, and the bytes that follow it do not change any register.
- R2: A write frame is address with R/W bit 0, then a pointer byte, then data bytes. Bits 6:0 of the pointer byte choose the register and bit 7 is ignored. Each data byte goes to the pointed register of the selected page, and the pointer then advances by one.
- R3: An address byte with R/W bit 1 starts a read. The target sends the register at the pointer MSB first, and after each master acknowledge it sends the next register. A master NACK or a STOP ends the read, and SDA is released from then on until the next addressed transfer.
- R4: The pointer saturates at 127. Further write bytes overwrite register 127, and further read bytes repeat register 127.
- R5: Register 0 selects the page on every page. Writing it stores the low `PG_W` bits, and reading it returns the page number. Registers 1 to 127 belong to the selected page only.
- R6: On page 0, register 107 is the control register: bit 2 is a read/write watchdog disable, bit 0 is the read-only sticky error flag, and the other bits read 0. On any other page, address 107 is an ordinary register.
- R7: If the target drives SDA low for `TIMEOUT` system clocks with no SCL edge, it releases SDA, returns to idle and sets the error flag. It does not release before that.
- R8: The error flag stays set until page 0 register 107 is read over the bus. That read still returns the flag as 1, and the flag is clear afterwards.
- R9: The watchdog is enabled after reset. While the disable bit is 1, a stalled transfer keeps SDA low and the flag stays clear.
- R10: After reset all registers read 0, the page is 0 and SDA is released.
- R11: The side port returns the stored value of register `host_addr` on page `host_page` combinationally. Address 0 returns the page number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | When 1, pull SDA low |
| host_page | input | PG_W | Page for the side read port |
| host_addr | input | 7 | Register for the side read port |
| host_rdata | output | 8 | Side read port data |

## Verification
The bench builds the target with two pages, device address 0x2C and a 64-clock watchdog timeout. The short timeout lets the bench stall a transfer, check SDA just before and just after the release, and clear the flag, all in a few hundred clocks. With only two pages, one burst can fill and read back every register of page 1 while page 0 stays untouched. The bench also sweeps all 128 device addresses and runs past the saturation point at register 127 in both directions.

// File: rtl/i2cpg_pkg.sv
package i2cpg_pkg;
   localparam int REG_AW   = 7;
   localparam int REG_LAST = (1 << REG_AW) - 1;
   localparam int CTRL_REG = 107;
   localparam int BIT_ERR  = 0;
   localparam int BIT_DIS  = 2;

   typedef enum logic [2:0] {
      S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK
   } state_t;

   typedef enum logic [1:0] {
      B_ADDR, B_REG, B_DATA
   } kind_t;
endpackage

// File: rtl/i2cpg_line_sync.sv
module i2cpg_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad
      $error("i2cpg_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_p, sda_p;
   logic scl_prev, sda_prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_p[g] <= 1'b1;
            sda_p[g] <= 1'b1;
         end else begin
            scl_p[g] <= (g == 0) ? scl_i : scl_p[(g == 0) ? 0 : g-1];
            sda_p[g] <= (g == 0) ? sda_i : sda_p[(g == 0) ? 0 : g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign scl_s     = scl_p[STAGES-1];
   assign sda_s     = sda_p[STAGES-1];
   assign scl_rise  = scl_s & ~scl_prev;
   assign scl_fall  = ~scl_s & scl_prev;
   assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2cpg_regfile.sv
module i2cpg_regfile import i2cpg_pkg::*; #(
   parameter int NUM_PAGES = 4,
   localparam int PG_W = $clog2(NUM_PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   input  logic              rd_strobe,
   output logic [7:0]        rd_data,
   input  logic              err_set,
   output logic              err_flag,
   output logic              det_dis,
   input  logic [PG_W-1:0]   host_page,
   input  logic [REG_AW-1:0] host_addr,
   output logic [7:0]        host_rdata
);
   localparam int NREG = 1 << REG_AW;

   logic [7:0]      mem [NUM_PAGES][NREG];
   logic [PG_W-1:0] page_q;

   function automatic logic [7:0] fetch(input logic [PG_W-1:0] pg,
                                         input logic [REG_AW-1:0] a);
      logic [7:0] v;
      if (a == '0) begin
         v = '0;
         v[PG_W-1:0] = page_q;
      end else if (pg == '0 && a == REG_AW'(CTRL_REG)) begin
         v = '0;
         v[BIT_DIS] = det_dis;
         v[BIT_ERR] = err_flag;
      end else begin
         v = mem[pg][a];
      end
      return v;
   endfunction

   wire ctrl_hit_wr = (page_q == '0) && (wr_addr == REG_AW'(CTRL_REG));
   wire ctrl_hit_rd = (page_q == '0) && (rd_addr == REG_AW'(CTRL_REG));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q  <= '0;
         det_dis <= 1'b0;
         for (int p = 0; p < NUM_PAGES; p++)
            for (int r = 0; r < NREG; r++)
               mem[p][r] <= '0;
      end else if (wr_en) begin
         if (wr_addr == '0)
            page_q <= wr_data[PG_W-1:0];
         else if (ctrl_hit_wr)
            det_dis <= wr_data[BIT_DIS];
         else
            mem[page_q][wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_flag <= 1'b0;
      else if (err_set)
         err_flag <= 1'b1;
      else if (rd_strobe && ctrl_hit_rd)
         err_flag <= 1'b0;
   end

   assign rd_data    = fetch(page_q, rd_addr);
   assign host_rdata = fetch(host_page, host_addr);
endmodule

// File: rtl/i2cpg_watchdog.sv
module i2cpg_watchdog #(
   parameter int TIMEOUT = 1024,
   localparam int CW = $clog2(TIMEOUT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic holding,
   input  logic scl_edge,
   output logic fire
);
   logic [CW-1:0] cnt;
   wire counting = enable & holding & ~scl_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!counting || fire)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign fire = counting && (cnt == CW'(TIMEOUT - 1));
endmodule

// File: rtl/i2cpg_target.sv
module i2cpg_target import i2cpg_pkg::*; #(
   parameter logic [6:0] DEV_ADDR    = 7'h1A,
   parameter int         NUM_PAGES   = 4,
   parameter int         TIMEOUT     = 1024,
   parameter int         SYNC_STAGES = 2,
   localparam int        PG_W        = $clog2(NUM_PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [PG_W-1:0]   host_page,
   input  logic [REG_AW-1:0] host_addr,
   output logic [7:0]        host_rdata
);
   if (NUM_PAGES < 2 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_pages
      $error("i2cpg_target: NUM_PAGES must be a power of two, at least 2");
   end
   if (TIMEOUT < 4) begin : g_bad_timeout
      $error("i2cpg_target: TIMEOUT must be at least 4");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic wd_fire, err_flag, det_dis;
   logic [7:0] rd_data;

   state_t            st;
   kind_t             kind;
   logic [7:0]        sh;
   logic [3:0]        cnt;
   logic [REG_AW-1:0] ptr;
   logic              rw, mack;

   i2cpg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   wire quiet     = ~wd_fire & ~stop_det & ~start_det;
   wire byte_done = (st == S_RX) && scl_fall && (cnt == 4'd8) && quiet;
   wire ptr_load  = byte_done && (kind == B_REG);
   wire wr_en     = byte_done && (kind == B_DATA);
   wire rd_strobe = quiet && scl_fall &&
                    ((st == S_RXACK && kind == B_ADDR && rw) || (st == S_TXACK && mack));
   wire [REG_AW-1:0] next_ptr = (ptr == REG_AW'(REG_LAST)) ? ptr : ptr + 1'b1;

   i2cpg_regfile #(.NUM_PAGES(NUM_PAGES)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(ptr), .wr_data(sh),
      .rd_addr(ptr), .rd_strobe(rd_strobe), .rd_data(rd_data),
      .err_set(wd_fire), .err_flag(err_flag), .det_dis(det_dis),
      .host_page(host_page), .host_addr(host_addr), .host_rdata(host_rdata));

   i2cpg_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
      .clk(clk), .rst_n(rst_n), .enable(~det_dis), .holding(sda_oe),
      .scl_edge(scl_rise | scl_fall), .fire(wd_fire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         kind   <= B_ADDR;
         sh     <= '0;
         cnt    <= '0;
         ptr    <= '0;
         rw     <= 1'b0;
         mack   <= 1'b0;
         sda_oe <= 1'b0;
      end else if (wd_fire || stop_det) begin
         st     <= S_IDLE;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         st     <= S_RX;
         kind   <= B_ADDR;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else begin
         unique case (st)
            S_RX: begin
               if (scl_rise && cnt != 4'd8) begin
                  sh  <= {sh[6:0], sda_s};
                  cnt <= cnt + 1'b1;
               end else if (byte_done) begin
                  cnt <= '0;
                  if (kind == B_ADDR) begin
                     if (sh[7:1] == DEV_ADDR) begin
                        rw     <= sh[0];
                        sda_oe <= 1'b1;
                        st     <= S_RXACK;
                     end else begin
                        st <= S_IDLE;
                     end
                  end else begin
                     ptr    <= (kind == B_REG) ? sh[REG_AW-1:0] : next_ptr;
                     sda_oe <= 1'b1;
                     st     <= S_RXACK;
                  end
               end
            end
            S_RXACK: begin
               if (scl_fall) begin
                  if (rd_strobe) begin
                     st     <= S_TX;
                     sh     <= rd_data;
                     sda_oe <= ~rd_data[7];
                     ptr    <= next_ptr;
                     cnt    <= '0;
                  end else begin
                     st     <= S_RX;
                     sda_oe <= 1'b0;
                     kind   <= (kind == B_ADDR) ? B_REG : B_DATA;
                  end
               end
            end
            S_TX: begin
               if (scl_fall) begin
                  if (cnt == 4'd7) begin
                     sda_oe <= 1'b0;
                     st     <= S_TXACK;
                  end else begin
                     sh     <= {sh[6:0], 1'b0};
                     sda_oe <= ~sh[6];
                     cnt    <= cnt + 1'b1;
                  end
               end
            end
            S_TXACK: begin
               if (scl_rise)
                  mack <= ~sda_s;
               else if (rd_strobe) begin
                  st     <= S_TX;
                  sh     <= rd_data;
                  sda_oe <= ~rd_data[7];
                  ptr    <= next_ptr;
                  cnt    <= '0;
               end else if (scl_fall)
                  st <= S_IDLE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2cpg_target_chk.sv
module i2cpg_target_chk import i2cpg_pkg::*; (
   input logic              clk,
   input logic              rst_n,
   input logic              sda_oe,
   input state_t            st,
   input logic              stop_det,
   input logic              wd_fire,
   input logic              err_flag,
   input logic              det_dis,
   input logic [REG_AW-1:0] ptr,
   input logic              ptr_load,
   input logic              rd_strobe
);
   assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) |-> !sda_oe);

   assert_stop_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   assert_ptr_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr == REG_AW'(REG_LAST) && !ptr_load) |=> (ptr == REG_AW'(REG_LAST)));

   assert_wd_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wd_fire |=> (!sda_oe && st == S_IDLE && err_flag));

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_flag) |-> $past(rd_strobe));

   assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      det_dis |-> !wd_fire);
endmodule

bind i2cpg_target i2cpg_target_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .st(st), .stop_det(stop_det),
   .wd_fire(wd_fire), .err_flag(err_flag), .det_dis(det_dis), .ptr(ptr),
   .ptr_load(ptr_load), .rd_strobe(rd_strobe));

// File: tb/tb_i2cpg_target.sv
`timescale 1ns/1ps
module tb_i2cpg_target;
   localparam logic [6:0] DEV = 7'h2C;
   localparam int NP = 2;
   localparam int TO = 64;
   localparam time Q = 20ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic [0:0] host_page = '0;
   logic [6:0] host_addr = '0;
   logic [7:0] host_rdata;
   wire sda_ln = sda_m & ~sda_oe;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   i2cpg_target #(.DEV_ADDR(DEV), .NUM_PAGES(NP), .TIMEOUT(TO)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_ln), .sda_oe(sda_oe),
      .host_page(host_page), .host_addr(host_addr), .host_rdata(host_rdata));

   function automatic logic [7:0] pat(input int k);
      return 8'((k * 37 + 11) & 255);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic host_rd(input int pg, input int a, output logic [7:0] v);
      host_page = 1'(pg);
      host_addr = 7'(a);
      #1;
      v = host_rdata;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #(2*Q);
   endtask

   task automatic send_bits8(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
      end
      sda_m = 1'b1;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits8(b);
      #Q; scl_m = 1'b1; #Q; ack = ~sda_ln; #Q; scl_m = 1'b0; #Q;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; b[i] = sda_ln; #Q; scl_m = 1'b0; #Q;
      end
      sda_m = ~mack; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
      sda_m = 1'b1;
   endtask

   task automatic wr1(input logic [7:0] r, input logic [7:0] v);
      logic a;
      bus_start(); send_byte({DEV, 1'b0}, a); send_byte(r, a); send_byte(v, a); bus_stop();
   endtask

   task automatic rd_open(input logic [7:0] r);
      logic a;
      bus_start(); send_byte({DEV, 1'b0}, a); send_byte(r, a);
      bus_start(); send_byte({DEV, 1'b1}, a);
   endtask

   task automatic rd1(input logic [7:0] r, output logic [7:0] v);
      rd_open(r); recv_byte(1'b0, v); bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic a;
      #(3*Q);
      rst_n = 1'b1;
      #(2*Q);

      // R10: reset state
      chk("R10 sda released", int'(sda_ln), 1);
      host_rd(0, 5, v);   chk("R10 reg zero", v, 0);
      host_rd(1, 90, v);  chk("R10 reg zero p1", v, 0);
      host_rd(0, 0, v);   chk("R10 page zero", v, 0);
      host_rd(0, 107, v); chk("R9 detector on at reset", v, 0);

      // R1: sweep every device address
      for (int d = 0; d < 128; d++) begin
         bus_start(); send_byte({7'(d), 1'b0}, a); bus_stop();
         chk("R1 ack only own address", int'(a), (7'(d) == DEV) ? 1 : 0);
      end
      bus_start(); send_byte({DEV ^ 7'h01, 1'b0}, a); send_byte(8'h05, a);
      send_byte(8'hAA, a); bus_stop();
      host_rd(0, 5, v); chk("R1 foreign frame ignored", v, 0);

      // R5: page select
      wr1(8'h00, 8'h01);
      host_rd(0, 0, v); chk("R5 page reg on page 0 view", v, 1);
      host_rd(1, 0, v); chk("R5 page reg on page 1 view", v, 1);

      // R2: burst write to page 1, then exhaustive side-port readback (R11)
      bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h01, a);
      for (int k = 1; k < 128; k++) send_byte(pat(k), a);
      bus_stop();
      for (int k = 1; k < 128; k++) begin
         host_rd(1, k, v); chk("R2 R11 burst write page 1", v, pat(k));
      end
      host_rd(0, 5, v); chk("R5 page 0 untouched", v, 0);
      host_rd(1, 107, v); chk("R6 page 1 reg 107 ordinary", v, pat(107));

      // R3 + R4: burst read past the end of the page
      rd_open(8'h01);
      for (int k = 1; k <= 129; k++) begin
         recv_byte(k != 129, v);
         chk((k > 127) ? "R4 read repeats last" : "R3 burst read", v, pat((k > 127) ? 127 : k));
      end
      chk("R3 released after NACK", int'(sda_ln), 1);
      bus_stop();

      rd_open(8'h0A);
      recv_byte(1'b1, v); chk("R3 read first", v, pat(10));
      recv_byte(1'b0, v); chk("R3 read second", v, pat(11));
      chk("R3 released after NACK", int'(sda_ln), 1);
      bus_stop();
      rd1(8'h00, v); chk("R5 page reads back", v, 1);

      // R4: write saturation
      bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h7E, a);
      send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); bus_stop();
      host_rd(1, 126, v); chk("R4 write before end", v, 8'h11);
      host_rd(1, 127, v); chk("R4 write holds at 127", v, 8'h33);

      // R6: control register on page 0
      wr1(8'h00, 8'h00);
      wr1(8'h6B, 8'hFF);
      rd1(8'h6B, v); chk("R6 control bits", v, 8'h04);
      wr1(8'h6B, 8'h00);
      wr1(8'h85, 8'h5A);
      host_rd(0, 5, v); chk("R2 pointer bit 7 ignored", v, 8'h5A);

      // R7: stall with the target acknowledging
      bus_start(); send_bits8({DEV, 1'b0});
      repeat (TO - 16) @(posedge clk);
      #1; chk("R7 held before timeout", int'(sda_ln), 0);
      repeat (32) @(posedge clk);
      #1; chk("R7 released after timeout", int'(sda_ln), 1);
      #Q;
      rd1(8'h6B, v); chk("R8 flag reads set", v, 8'h01);
      rd1(8'h6B, v); chk("R8 flag cleared by read", v, 8'h00);

      // R9: detector disabled
      wr1(8'h6B, 8'h04);
      bus_start(); send_bits8({DEV, 1'b0});
      repeat (3 * TO) @(posedge clk);
      #1; chk("R9 disabled keeps hold", int'(sda_ln), 0);
      #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
      bus_stop();
      rd1(8'h6B, v); chk("R9 no flag when disabled", v, 8'h04);
      wr1(8'h6B, 8'h00);
      host_rd(0, 107, v); chk("R9 re-enabled", v, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule